// File: doc/BRIEF.md
# Supply Fault Event Register

This block keeps a sticky record of supply and thermal faults for a power controller that drives several output ports. It watches five synchronized inputs: a thermal shutdown flag, a logic-supply undervoltage flag, a power-rail undervoltage warning, a power-rail deep undervoltage flag and an external reset request. Three of these inputs are latched into active-high event bits of one byte. The byte can be read through a small command interface. One command code reads it without any side effect. A second command code returns the same byte and then clears it.

A three-state sequencer sets the operating mode. `S_POR` is the power-on state: the byte is held at its power-on value and reads get no answer. `S_RUN` is normal operation. `S_XRST` is entered while the external reset is held: only the power-rail event can be recorded there, and reads get no answer. The transitions are:
- `S_POR -> S_RUN` when the deep undervoltage flag is low.
- `S_RUN -> S_XRST` when the external reset rises.
- `S_XRST -> S_RUN` when the external reset is released.
- Any state goes to `S_POR` while the deep undervoltage flag is high.

The block raises an interrupt request from the enabled event bits. It issues a one-cycle port power-off pulse when the thermal, rail-warning or deep-undervoltage input rises. It also flags a full power-on reset while it is in `S_POR`.

Top module: `supfault_evreg`

## Requirements
- R1: Asynchronous reset puts the sequencer in `S_POR` with `por_o` high, `rd_valid_o`, `rd_data_o` and `port_off_o` all low, and the event byte at 0x30. After reset, the first read in `S_RUN` returns 0x30.
- R2: A strobe with command 0x0A in `S_RUN` gives `rd_valid_o` = 1 and `rd_data_o` = the event byte one cycle later. The byte is not changed.
- R3: A strobe with command 0x0B in `S_RUN` returns the byte as it was before the access, with the same one-cycle timing. Every bit is then cleared.
- R4: The byte layout is bit 7 = thermal event, bit 5 = logic-supply undervoltage event, bit 4 = power-rail undervoltage event. Bits 6 and 3..0 always read 0.
- R5: In `S_RUN`, an event bit is set on any cycle its input is high. It stays set after the input falls, until a 0x0B access or a return to `S_POR`.
- R6: If an event input is high in the same cycle as a 0x0B access, its bit is still set afterwards.
- R7: `irq_o` is the OR of event bits AND `irq_en_i`, where `irq_en_i[2]` = thermal, `[1]` = logic supply and `[0]` = power rail. A 0x0B access with no fault input active drops `irq_o` on the next cycle.
- R8: `port_off_o` is high for exactly one cycle, on the cycle after a rising edge of the thermal, rail-warning or deep-undervoltage input.
- R9: While the deep undervoltage input is high, the sequencer is in `S_POR`, `por_o` is high and the byte reloads to 0x30. Reads get no answer. The sequencer leaves `S_POR` the cycle after the input falls.
- R10: In `S_XRST`, the thermal and logic-supply inputs are ignored, the rail-warning input still sets bit 4, and reads get no answer.
- R11: A strobe with any other command code, or a strobe outside `S_RUN`, leaves `rd_valid_o` and `rd_data_o` at 0 and does not change the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| thermal_i | input | 1 | Thermal shutdown active |
| vdd_uv_i | input | 1 | Logic supply below undervoltage threshold |
| rail_warn_i | input | 1 | Power rail below its first falling threshold |
| rail_deep_i | input | 1 | Power rail below its deep undervoltage threshold |
| ext_rst_i | input | 1 | External reset held |
| rd_stb_i | input | 1 | Read strobe, one cycle per access |
| rd_cmd_i | input | 8 | Command code of the access |
| irq_en_i | input | 3 | Per-event interrupt enables |
| rd_data_o | output | 8 | Returned event byte, zero when not valid |
| rd_valid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Interrupt request |
| port_off_o | output | 1 | One-cycle request to power off all ports |
| por_o | output | 1 | Full power-on reset in progress |

## Verification
The bench builds the block with its default 8-bit command and data widths. It therefore drives the two real command codes as well as random neighbouring codes that must be rejected. It reads the byte back only through its own read commands, so reserved bit positions and pre-clear capture are both visible.

Random toggling of the deep-undervoltage and external-reset inputs makes every sequencer transition happen many times. This includes entry to `S_POR` straight from `S_XRST`, and reads that fall in the cycle a state changes.

// File: rtl/supfault_pkg.sv
package supfault_pkg;

    localparam int NUM_EV    = 3;
    localparam int IDX_RAIL  = 0;
    localparam int IDX_VDD   = 1;
    localparam int IDX_THERM = 2;

    localparam int BYTE_W = 8;
    localparam int CMD_W  = 8;

    localparam logic [CMD_W-1:0]  CMD_PEEK = 8'h0A;
    localparam logic [CMD_W-1:0]  CMD_TAKE = 8'h0B;
    localparam logic [NUM_EV-1:0] EV_POR   = 3'b011;

    // bit position of each event inside the returned byte
    function automatic int ev_pos(input int idx);
        case (idx)
            IDX_RAIL:  return 4;
            IDX_VDD:   return 5;
            default:   return 7;
        endcase
    endfunction

    typedef enum logic [1:0] {
        S_POR  = 2'd0,
        S_RUN  = 2'd1,
        S_XRST = 2'd2
    } seq_state_t;

endpackage

// File: rtl/supfault_seq.sv
module supfault_seq
    import supfault_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rail_deep_i,
    input  logic       ext_rst_i,
    output seq_state_t st_o,
    output logic       reload_o,
    output logic       run_o,
    output logic       xrst_o
);

    seq_state_t st_q;
    seq_state_t st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_POR;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (rail_deep_i) begin
            st_d = S_POR;
        end else begin
            unique case (st_q)
                S_POR:   st_d = S_RUN;
                S_RUN:   st_d = ext_rst_i ? S_XRST : S_RUN;
                S_XRST:  st_d = ext_rst_i ? S_XRST : S_RUN;
                default: st_d = S_POR;
            endcase
        end
    end

    always_comb begin
        reload_o = 1'b0;
        run_o    = 1'b0;
        xrst_o   = 1'b0;
        unique case (st_q)
            S_POR:   reload_o = 1'b1;
            S_RUN:   run_o    = 1'b1;
            S_XRST:  xrst_o   = 1'b1;
            default: reload_o = 1'b1;
        endcase
    end

    assign st_o = st_q;

endmodule

// File: rtl/supfault_evbit.sv
module supfault_evbit #(
    parameter logic POR_VAL  = 1'b0,
    parameter bit   XRST_SET = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload_i,
    input  logic run_i,
    input  logic xrst_i,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    // set wins over clear so an event coinciding with a clearing read survives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  q_o <= POR_VAL;
        else if (reload_i)           q_o <= POR_VAL;
        else if (run_i)              q_o <= (q_o & ~clr_i) | set_i;
        else if (xrst_i && XRST_SET) q_o <= q_o | set_i;
    end

endmodule

// File: rtl/supfault_rise.sv
module supfault_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);

    logic lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~lvl_q;

endmodule

// File: rtl/supfault_evreg.sv
module supfault_evreg
    import supfault_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              thermal_i,
    input  logic              vdd_uv_i,
    input  logic              rail_warn_i,
    input  logic              rail_deep_i,
    input  logic              ext_rst_i,
    input  logic              rd_stb_i,
    input  logic [CMD_W-1:0]  rd_cmd_i,
    input  logic [NUM_EV-1:0] irq_en_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              irq_o,
    output logic              port_off_o,
    output logic              por_o
);

    localparam int NUM_OFF = 3;

    seq_state_t        st;
    logic              reload;
    logic              run;
    logic              xrst;
    logic [NUM_EV-1:0] set_vec;
    logic [NUM_EV-1:0] ev_q;
    logic [BYTE_W-1:0] ev_byte;
    logic              served;
    logic              take;
    logic [NUM_OFF-1:0] off_src;
    logic [NUM_OFF-1:0] off_rise;

    supfault_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rail_deep_i(rail_deep_i),
        .ext_rst_i  (ext_rst_i),
        .st_o       (st),
        .reload_o   (reload),
        .run_o      (run),
        .xrst_o     (xrst)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[IDX_THERM] = thermal_i;
        set_vec[IDX_VDD]   = vdd_uv_i;
        set_vec[IDX_RAIL]  = rail_warn_i;
    end

    assign served = run && rd_stb_i && (rd_cmd_i == CMD_PEEK || rd_cmd_i == CMD_TAKE);
    assign take   = served && (rd_cmd_i == CMD_TAKE);

    for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
        supfault_evbit #(
            .POR_VAL (EV_POR[i]),
            .XRST_SET(i == IDX_RAIL)
        ) u_bit (
            .clk     (clk),
            .rst_n   (rst_n),
            .reload_i(reload),
            .run_i   (run),
            .xrst_i  (xrst),
            .set_i   (set_vec[i]),
            .clr_i   (take),
            .q_o     (ev_q[i])
        );
    end

    always_comb begin
        ev_byte = '0;
        for (int i = 0; i < NUM_EV; i++) begin
            ev_byte[ev_pos(i)] = ev_q[i];
        end
    end

    // captured from the pre-clear value in the same edge that clears
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= served;
            rd_data_o  <= served ? ev_byte : '0;
        end
    end

    assign off_src = {rail_deep_i, rail_warn_i, thermal_i};

    for (genvar k = 0; k < NUM_OFF; k++) begin : g_off
        supfault_rise u_rise (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl_i (off_src[k]),
            .rise_o(off_rise[k])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) port_off_o <= 1'b0;
        else        port_off_o <= |off_rise;
    end

    assign irq_o = |(ev_q & irq_en_i);
    assign por_o = reload;

endmodule

// File: rtl/supfault_chk.sv
module supfault_chk
    import supfault_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              thermal_i,
    input  logic              vdd_uv_i,
    input  logic              rail_warn_i,
    input  logic              rail_deep_i,
    input  logic              rd_stb_i,
    input  logic [CMD_W-1:0]  rd_cmd_i,
    input  logic [BYTE_W-1:0] rd_data_o,
    input  logic              rd_valid_o,
    input  logic              irq_o,
    input  logic              port_off_o,
    input  logic              por_o,
    input  logic [NUM_EV-1:0] ev_q,
    input  seq_state_t        st
);

    logic [NUM_EV-1:0] setv;
    assign setv = {thermal_i, vdd_uv_i, rail_warn_i};

    // R11
    valid_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(rd_stb_i && (rd_cmd_i == CMD_PEEK || rd_cmd_i == CMD_TAKE)));

    // R11
    idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid_o |-> (rd_data_o == '0));

    // R5
    sticky_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(ev_q) & ~ev_q) != '0) |-> ($past(por_o) || $past(rd_stb_i && rd_cmd_i == CMD_TAKE)));

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RUN) |=> ((ev_q & $past(setv)) == $past(setv)));

    // R7
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RUN && rd_stb_i && rd_cmd_i == CMD_TAKE && setv == '0 && !rail_deep_i) |=> !irq_o);

    // R8
    port_off_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(thermal_i) || $rose(rail_warn_i) || $rose(rail_deep_i)) |=> port_off_o);

    // R9
    por_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por_o |=> (ev_q == EV_POR));

    // R10
    xrst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_XRST) |=> (ev_q[IDX_THERM] == $past(ev_q[IDX_THERM]) && ev_q[IDX_VDD] == $past(ev_q[IDX_VDD])));

endmodule

bind supfault_evreg supfault_chk u_supfault_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .thermal_i  (thermal_i),
    .vdd_uv_i   (vdd_uv_i),
    .rail_warn_i(rail_warn_i),
    .rail_deep_i(rail_deep_i),
    .rd_stb_i   (rd_stb_i),
    .rd_cmd_i   (rd_cmd_i),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o),
    .irq_o      (irq_o),
    .port_off_o (port_off_o),
    .por_o      (por_o),
    .ev_q       (ev_q),
    .st         (st)
);

// File: tb/test_supfault_evreg.sv
`timescale 1ns/1ps
module test_supfault_evreg;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       thermal, vdd_uv, rail_warn, rail_deep, ext_rst, rd_stb;
    logic [7:0] rd_cmd;
    logic [2:0] irq_en;
    logic [7:0] rd_data;
    logic       rd_valid, irq, port_off, por;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // bench model: state 0 = power-on, 1 = run, 2 = external reset
    int         m_st;
    logic [2:0] m_ev;
    logic       m_off, p_th, p_wa, p_de;

    always #2.5 clk = ~clk;

    supfault_evreg i_supfault_evreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .thermal_i  (thermal),
        .vdd_uv_i   (vdd_uv),
        .rail_warn_i(rail_warn),
        .rail_deep_i(rail_deep),
        .ext_rst_i  (ext_rst),
        .rd_stb_i   (rd_stb),
        .rd_cmd_i   (rd_cmd),
        .irq_en_i   (irq_en),
        .rd_data_o  (rd_data),
        .rd_valid_o (rd_valid),
        .irq_o      (irq),
        .port_off_o (port_off),
        .por_o      (por)
    );

    function automatic logic [7:0] to_byte(input logic [2:0] ev);
        return {ev[2], 1'b0, ev[1], ev[0], 4'b0000};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        logic       served, take;
        logic [7:0] exp_data;
        logic [2:0] setv, nev;
        int         nst;
        string      t;
        @(posedge clk);
        served   = (m_st == 1) && rd_stb && (rd_cmd == 8'h0A || rd_cmd == 8'h0B);
        take     = served && (rd_cmd == 8'h0B);
        exp_data = served ? to_byte(m_ev) : 8'h00;
        setv     = {thermal, vdd_uv, rail_warn};
        case (m_st)
            0:       nev = 3'b011;
            1:       nev = (take ? 3'b000 : m_ev) | setv;
            default: nev = m_ev | {2'b00, rail_warn};
        endcase
        m_off = (thermal & ~p_th) | (rail_warn & ~p_wa) | (rail_deep & ~p_de);
        p_th = thermal; p_wa = rail_warn; p_de = rail_deep;
        if (rail_deep)      nst = 0;
        else if (m_st == 0) nst = 1;
        else                nst = ext_rst ? 2 : 1;
        m_ev = nev;
        m_st = nst;
        t = take ? "R3" : (served ? "R2" : "R11");
        #1;
        check(t, {7'd0, rd_valid}, {7'd0, served});
        check(t, rd_data, exp_data);
        check("R7", {7'd0, irq}, {7'd0, |(m_ev & irq_en)});
        check("R8", {7'd0, port_off}, {7'd0, m_off});
        check("R9", {7'd0, por}, {7'd0, m_st == 0});
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] cmd);
        rd_stb = 1'b1;
        rd_cmd = cmd;
        tick();
        rd_stb = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        rst_n = 1'b0;
        thermal = 0; vdd_uv = 0; rail_warn = 0; rail_deep = 0; ext_rst = 0;
        rd_stb = 0; rd_cmd = 8'h00; irq_en = 3'b111;
        m_st = 0; m_ev = 3'b011; m_off = 0; p_th = 0; p_wa = 0; p_de = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1", {7'd0, por}, 8'd1);
        check("R1", {7'd0, rd_valid}, 8'd0);
        check("R1", rd_data, 8'h00);
        check("R1", {7'd0, port_off}, 8'd0);
        check("R1", {7'd0, irq}, 8'd1);
        rst_n = 1'b1;
        tick();
        check("R9", {7'd0, por}, 8'd0);

        rd(8'h0A);
        check("R1", rd_data, 8'h30);
        check("R4", rd_data & 8'h4F, 8'h00);
        rd(8'h0B);
        check("R3", rd_data, 8'h30);
        check("R7", {7'd0, irq}, 8'd0);
        rd(8'h0A);
        check("R3", rd_data, 8'h00);

        // thermal event, sticky after it falls
        thermal = 1; tick();
        check("R8", {7'd0, port_off}, 8'd1);
        thermal = 0; tick();
        check("R8", {7'd0, port_off}, 8'd0);
        rd(8'h0A);
        check("R5", rd_data, 8'h80);
        check("R4", rd_data, 8'h80);
        irq_en = 3'b011; tick();
        check("R7", {7'd0, irq}, 8'd0);
        irq_en = 3'b111; tick();
        check("R7", {7'd0, irq}, 8'd1);

        // set beats clear
        thermal = 1; rd(8'h0B);
        check("R6", rd_data, 8'h80);
        thermal = 0; rd(8'h0A);
        check("R6", rd_data, 8'h80);
        rd(8'h0B);

        // unknown command
        vdd_uv = 1; tick(); vdd_uv = 0;
        rd(8'h0C);
        check("R11", {7'd0, rd_valid}, 8'd0);
        rd(8'h0A);
        check("R11", rd_data, 8'h20);
        rd(8'h0B);

        // external reset: only rail bit records
        ext_rst = 1; tick();
        thermal = 1; vdd_uv = 1; rail_warn = 1;
        rd(8'h0A);
        check("R10", {7'd0, rd_valid}, 8'd0);
        tick();
        ext_rst = 0; thermal = 0; vdd_uv = 0; rail_warn = 0;
        tick();
        rd(8'h0A);
        check("R10", rd_data, 8'h10);
        rd(8'h0B);

        // deep undervoltage
        rail_deep = 1; tick();
        check("R9", {7'd0, por}, 8'd1);
        rd(8'h0A);
        check("R9", {7'd0, rd_valid}, 8'd0);
        rail_deep = 0; tick();
        rd(8'h0A);
        check("R9", rd_data, 8'h30);

        // constrained random phase
        for (int c = 0; c < 4000; c++) begin
            if ($urandom % 8 == 0)  thermal   = ~thermal;
            if ($urandom % 8 == 0)  vdd_uv    = ~vdd_uv;
            if ($urandom % 8 == 0)  rail_warn = ~rail_warn;
            if ($urandom % 40 == 0) rail_deep = ~rail_deep;
            if ($urandom % 30 == 0) ext_rst   = ~ext_rst;
            if ($urandom % 50 == 0) irq_en    = 3'($urandom);
            rd_stb = ($urandom % 2) == 1;
            case ($urandom % 4)
                0:       rd_cmd = 8'h0A;
                1:       rd_cmd = 8'h0B;
                2:       rd_cmd = 8'h0B;
                default: rd_cmd = 8'($urandom);
            endcase
            tick();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule